// File: doc/BRIEF.md
# Nybble Move-and-Branch Sequencer

This block is the control unit of a small 4-bit processor that addresses 4096 nybbles of main memory. Every instruction begins with an opcode nybble whose upper two bits pick one of four classes: a move, an unconditional jump, a jump if a chosen status bit is clear, and a jump if a chosen status bit is set. Operand nybbles follow the opcode. The sequencer fetches them one per cycle from a memory port that returns read data one cycle after the request. It then performs the transfer or branch the opcode describes.

Arithmetic is not done here. A bank of up to sixteen function units sits in its own address space. The sequencer can write a unit's carry bit, read a unit's data nybble and test one bit of a unit's status nybble. It also loads the shared A and B operand registers that feed those units. The bottom sixteen main-memory addresses act as a read-only table of the constants 0 to 15, so programs can copy literals with an ordinary move. Execution begins at address 0x010 after reset.

Top module: `nyb_seq_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the sequencer requests a read of address 0x010. In that cycle it asserts no memory write, register write or carry write.
- R2: The opcode bits [3:2] select the class: 00 move, 01 jump, 10 jump-if-clear, 11 jump-if-set. The opcode is followed by the class's operand nybbles: move kinds 00/01/10/11 take 6/4/2/4 operands, a jump takes 3 and a conditional jump takes 4. The next opcode is fetched from the nybble after the last operand unless a jump is taken.
- R3: Move kind 00 reads a 3-nybble source address and then a 3-nybble destination address. It reads the source and writes that nybble to the destination in the following cycle.
- R4: Move kind 01 reads a 3-nybble source address and then a destination nybble. Destination 0 loads register A (reg_sel=0) and destination 1 loads register B (reg_sel=1). Any other destination value writes no register.
- R5: Move kind 10 reads a data nybble and then a unit address. It pulses fu_cwe for one cycle with fu_addr equal to the unit and fu_cdata equal to bit 0 of the data nybble.
- R6: Move kind 11 reads a unit address and then a 3-nybble destination. It writes that unit's data nybble (fu_data) to the destination.
- R7: A jump loads the PC from its three operand nybbles. The opcode's low two bits have no effect.
- R8: A conditional jump reads a unit address and then a 3-nybble target. Opcode bits [1:0] choose the status bit. The jump is taken when that bit equals opcode bit 2, and the next opcode is then fetched from the target.
- R9: A read of any address from 0x000 to 0x00F returns the address's low nybble, whatever the external memory holds there. This applies to opcodes, operands and move sources alike.
- R10: A write aimed at an address from 0x000 to 0x00F produces no mem_we pulse.
- R11: Every address formed by incrementing the PC wraps from 0xFFF to 0x000.
- R12: Read data is taken the cycle after mem_rd. Multi-nybble addresses arrive most-significant nybble first. No cycle asserts mem_rd and mem_we together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Main-memory read request |
| mem_we | output | 1 | Main-memory write strobe |
| mem_addr | output | 12 | Main-memory address for read or write |
| mem_wdata | output | 4 | Main-memory write data |
| mem_rdata | input | 4 | Read data, valid the cycle after mem_rd |
| reg_we | output | 1 | Operand register write strobe |
| reg_sel | output | 1 | 0 selects register A, 1 selects register B |
| reg_wdata | output | 4 | Operand register write data |
| fu_addr | output | 4 | Function unit address |
| fu_cwe | output | 1 | Carry bit write strobe for the addressed unit |
| fu_cdata | output | 1 | Carry bit value to write |
| fu_data | input | 4 | Data nybble of the addressed unit (combinational) |
| fu_status | input | 4 | Status nybble of the addressed unit (combinational) |

## Verification
Two functions meet in one cycle: the constant overlay and the write of a memory-to-memory copy. The cycle that stores the copied nybble is the same cycle in which the overlay decides whether that nybble comes from the fixed table or from external memory. The bench provokes this by copying from 0x009 while the external model holds a different value there, and by copying into 0x005. The first copy must store 9. The second must leave no write at the port and leave the model's low region untouched. A wrap test also runs instructions whose opcodes and operands come from the constant table right after the PC passes 0xFFF. There the overlay and the fetch increment act together on every cycle.

// File: rtl/nyb_seq_pkg.sv
package nyb_seq_pkg;

  localparam int NYB_W    = 4;
  localparam int ADDR_NYB = 3;
  localparam int ADDR_W   = NYB_W * ADDR_NYB;
  localparam int OPND_MAX = 2 * ADDR_NYB;
  localparam int CNT_W    = $clog2(OPND_MAX + 1);

  typedef logic [NYB_W-1:0]  nyb_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    CLS_MOVE = 2'b00,
    CLS_JUMP = 2'b01,
    CLS_JCLR = 2'b10,
    CLS_JSET = 2'b11
  } op_cls_e;

  typedef enum logic [1:0] {
    MV_MEM_MEM = 2'b00,
    MV_MEM_REG = 2'b01,
    MV_DAT_FU  = 2'b10,
    MV_FU_MEM  = 2'b11
  } mv_kind_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPCODE,
    ST_OPERAND,
    ST_EXEC,
    ST_COPY,
    ST_LOADREG
  } seq_state_e;

  // number of operand nybbles that follow an opcode
  function automatic logic [CNT_W-1:0] operand_count(input nyb_t op);
    logic [CNT_W-1:0] n;
    case (op[3:2])
      2'b00: begin
        case (op[1:0])
          2'b00:   n = CNT_W'(2 * ADDR_NYB);
          2'b01:   n = CNT_W'(ADDR_NYB + 1);
          2'b10:   n = CNT_W'(2);
          default: n = CNT_W'(ADDR_NYB + 1);
        endcase
      end
      2'b01:   n = CNT_W'(ADDR_NYB);
      default: n = CNT_W'(ADDR_NYB + 1);
    endcase
    return n;
  endfunction

  function automatic addr_t addr_step(input addr_t a);
    return a + addr_t'(1);
  endfunction

endpackage

// File: rtl/nyb_mem_guard.sv
module nyb_mem_guard
  import nyb_seq_pkg::*;
#(
  parameter int CONST_TOP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NYB_W-1:0]  ext_rdata,
  output logic [NYB_W-1:0]  rd_data,
  output logic              wr_ok
);

  localparam addr_t TOP_A = addr_t'(CONST_TOP);

  logic in_const;
  logic held_const;
  nyb_t held_low;

  assign in_const = (addr < TOP_A);

  // remember where the outstanding read pointed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_const <= 1'b0;
      held_low   <= '0;
    end else if (rd_req) begin
      held_const <= in_const;
      held_low   <= addr[NYB_W-1:0];
    end
  end

  assign rd_data = held_const ? held_low : ext_rdata;
  assign wr_ok   = wr_req && !in_const;

endmodule

// File: rtl/nyb_opnd_buf.sv
module nyb_opnd_buf
  import nyb_seq_pkg::*;
#(
  parameter int DEPTH = OPND_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   shift_en,
  input  logic [NYB_W-1:0]       din,
  output logic [DEPTH*NYB_W-1:0] bits,
  output logic [CNT_W-1:0]       count
);

  localparam int BW = DEPTH * NYB_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits  <= '0;
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (shift_en) begin
      bits  <= {bits[BW-NYB_W-1:0], din};
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/nyb_cond_eval.sv
module nyb_cond_eval
  import nyb_seq_pkg::*;
(
  input  logic [1:0]       bit_sel,
  input  logic             want_set,
  input  logic [NYB_W-1:0] status,
  output logic             taken
);

  logic [NYB_W-1:0] match;

  for (genvar b = 0; b < NYB_W; b++) begin : g_match
    assign match[b] = (status[b] == want_set);
  end

  assign taken = match[bit_sel];

endmodule

// File: rtl/nyb_seq_core.sv
module nyb_seq_core
  import nyb_seq_pkg::*;
#(
  parameter int START_PC  = 16,
  parameter int CONST_TOP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NYB_W-1:0]  mem_wdata,
  input  logic [NYB_W-1:0]  mem_rdata,
  output logic              reg_we,
  output logic              reg_sel,
  output logic [NYB_W-1:0]  reg_wdata,
  output logic [NYB_W-1:0]  fu_addr,
  output logic              fu_cwe,
  output logic              fu_cdata,
  input  logic [NYB_W-1:0]  fu_data,
  input  logic [NYB_W-1:0]  fu_status
);

  localparam addr_t START_A = addr_t'(START_PC);
  localparam int    BUF_W   = OPND_MAX * NYB_W;

  seq_state_e state_q, state_d;
  addr_t      pc_q, pc_d;
  nyb_t       op_q, op_d;
  addr_t      dst_q, dst_d;
  nyb_t       rdst_q, rdst_d;

  logic [BUF_W-1:0] opnd;
  logic [CNT_W-1:0] opnd_cnt;
  logic             buf_clear, buf_shift;
  logic             rd_req, wr_req;
  addr_t            acc_addr;
  nyb_t             rd_nyb;
  logic             cond_hit;
  logic             last_opnd;

  // named events for the checker
  logic  exec_cycle;
  logic  jump_taken;
  addr_t jump_target;

  op_cls_e  cls;
  mv_kind_e kind;
  assign cls  = op_cls_e'(op_q[3:2]);
  assign kind = mv_kind_e'(op_q[1:0]);

  // operand fields, oldest nybble in the highest position
  addr_t m2m_src, tail_addr, m2r_src;
  nyb_t  m2r_dst, d2f_val, low_unit, hi_unit;
  assign m2m_src   = opnd[2*ADDR_W-1:ADDR_W];
  assign tail_addr = opnd[ADDR_W-1:0];
  assign m2r_src   = opnd[ADDR_W+NYB_W-1:NYB_W];
  assign m2r_dst   = opnd[NYB_W-1:0];
  assign d2f_val   = opnd[2*NYB_W-1:NYB_W];
  assign low_unit  = opnd[NYB_W-1:0];
  assign hi_unit   = opnd[ADDR_W+NYB_W-1:ADDR_W];

  nyb_mem_guard #(.CONST_TOP(CONST_TOP)) i_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .addr      (acc_addr),
    .ext_rdata (mem_rdata),
    .rd_data   (rd_nyb),
    .wr_ok     (mem_we)
  );

  nyb_opnd_buf #(.DEPTH(OPND_MAX)) i_opnd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (buf_clear),
    .shift_en (buf_shift),
    .din      (rd_nyb),
    .bits     (opnd),
    .count    (opnd_cnt)
  );

  nyb_cond_eval i_cond (
    .bit_sel  (op_q[1:0]),
    .want_set (op_q[2]),
    .status   (fu_status),
    .taken    (cond_hit)
  );

  assign mem_rd    = rd_req;
  assign mem_addr  = acc_addr;
  assign last_opnd = ((opnd_cnt + CNT_W'(1)) == operand_count(op_q));

  assign exec_cycle  = (state_q == ST_EXEC);
  assign jump_taken  = exec_cycle &&
                       ((cls == CLS_JUMP) ||
                        (((cls == CLS_JCLR) || (cls == CLS_JSET)) && cond_hit));
  assign jump_target = tail_addr;

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    op_d      = op_q;
    dst_d     = dst_q;
    rdst_d    = rdst_q;
    rd_req    = 1'b0;
    wr_req    = 1'b0;
    acc_addr  = pc_q;
    mem_wdata = '0;
    reg_we    = 1'b0;
    reg_sel   = 1'b0;
    reg_wdata = '0;
    fu_addr   = '0;
    fu_cwe    = 1'b0;
    fu_cdata  = 1'b0;
    buf_clear = 1'b0;
    buf_shift = 1'b0;

    case (state_q)
      ST_FETCH: begin
        rd_req  = 1'b1;
        pc_d    = addr_step(pc_q);
        state_d = ST_OPCODE;
      end

      ST_OPCODE: begin
        op_d      = rd_nyb;
        buf_clear = 1'b1;
        rd_req    = 1'b1;
        pc_d      = addr_step(pc_q);
        state_d   = ST_OPERAND;
      end

      ST_OPERAND: begin
        buf_shift = 1'b1;
        if (last_opnd) begin
          state_d = ST_EXEC;
        end else begin
          rd_req = 1'b1;
          pc_d   = addr_step(pc_q);
        end
      end

      ST_EXEC: begin
        state_d = ST_FETCH;
        case (cls)
          CLS_MOVE: begin
            case (kind)
              MV_MEM_MEM: begin
                rd_req   = 1'b1;
                acc_addr = m2m_src;
                dst_d    = tail_addr;
                state_d  = ST_COPY;
              end
              MV_MEM_REG: begin
                rd_req   = 1'b1;
                acc_addr = m2r_src;
                rdst_d   = m2r_dst;
                state_d  = ST_LOADREG;
              end
              MV_DAT_FU: begin
                fu_addr  = low_unit;
                fu_cwe   = 1'b1;
                fu_cdata = d2f_val[0];
              end
              default: begin
                fu_addr   = hi_unit;
                wr_req    = 1'b1;
                acc_addr  = tail_addr;
                mem_wdata = fu_data;
              end
            endcase
          end
          CLS_JUMP: begin
            pc_d = jump_target;
          end
          default: begin
            fu_addr = hi_unit;
            if (jump_taken) pc_d = jump_target;
          end
        endcase
      end

      ST_COPY: begin
        wr_req    = 1'b1;
        acc_addr  = dst_q;
        mem_wdata = rd_nyb;
        state_d   = ST_FETCH;
      end

      ST_LOADREG: begin
        if (rdst_q[NYB_W-1:1] == '0) begin
          reg_we    = 1'b1;
          reg_sel   = rdst_q[0];
          reg_wdata = rd_nyb;
        end
        state_d = ST_FETCH;
      end

      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= START_A;
      op_q    <= '0;
      dst_q   <= '0;
      rdst_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      op_q    <= op_d;
      dst_q   <= dst_d;
      rdst_q  <= rdst_d;
    end
  end

endmodule

// File: rtl/nyb_seq_chk.sv
module nyb_seq_chk
  import nyb_seq_pkg::*;
#(
  parameter int START_PC  = 16,
  parameter int CONST_TOP = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              reg_we,
  input logic              fu_cwe,
  input logic              jump_taken,
  input logic [ADDR_W-1:0] jump_target
);

  logic seen_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge |-> (mem_rd && (mem_addr == addr_t'(START_PC)) && !mem_we && !reg_we && !fu_cwe));

  // R12
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R10
  const_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= addr_t'(CONST_TOP)));

  // R8
  jump_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> (mem_rd && (mem_addr == $past(jump_target))));

  // R4
  reg_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(mem_rd));

  // R5
  carry_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_cwe |-> (!mem_rd && !mem_we && !reg_we));

endmodule

bind nyb_seq_core nyb_seq_chk #(.START_PC(START_PC), .CONST_TOP(CONST_TOP)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .reg_we      (reg_we),
  .fu_cwe      (fu_cwe),
  .jump_taken  (jump_taken),
  .jump_target (jump_target)
);

// File: tb/test_nyb_seq_core.sv
module test_nyb_seq_core;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd, mem_we, reg_we, reg_sel, fu_cwe, fu_cdata;
  logic [11:0] mem_addr;
  logic [3:0]  mem_wdata, reg_wdata, fu_addr;
  logic [3:0]  rdata = 4'h0;
  logic [3:0]  fb_rd, fb_st;

  logic [3:0]  mem [0:4095];
  logic [3:0]  fb_data [0:15];
  logic [3:0]  fb_stat [0:15];
  logic [11:0] rlog [0:63];
  int rcnt, wcnt, low_wr, both, rw_cnt, cw_cnt;
  logic rw_sel, cw_val;
  logic [3:0] rw_val, cw_unit;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  assign fb_rd = fb_data[fu_addr];
  assign fb_st = fb_stat[fu_addr];

  nyb_seq_core i_nyb_seq_core (
    .clk(clk), .rst_n(rst_n),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .fu_addr(fu_addr), .fu_cwe(fu_cwe), .fu_cdata(fu_cdata),
    .fu_data(fb_rd), .fu_status(fb_st)
  );

  // behavioural memory, register pair and carry observer
  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= 0; wcnt <= 0; low_wr <= 0; both <= 0; rw_cnt <= 0; cw_cnt <= 0;
    end else begin
      if (mem_rd) begin
        rdata <= mem[mem_addr];
        if (rcnt < 64) rlog[rcnt] <= mem_addr;
        rcnt <= rcnt + 1;
      end
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wcnt <= wcnt + 1;
        if (mem_addr < 12'h010) low_wr <= low_wr + 1;
      end
      if (mem_rd && mem_we) both <= both + 1;
      if (reg_we) begin
        rw_cnt <= rw_cnt + 1; rw_sel <= reg_sel; rw_val <= reg_wdata;
      end
      if (fu_cwe) begin
        cw_cnt <= cw_cnt + 1; cw_unit <= fu_addr; cw_val <= fu_cdata;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = (i < 16) ? 4'((i + 5) & 15) : 4'h0;
  endtask

  task automatic put(input int a, input logic [3:0] v);
    mem[a & 12'hFFF] = v;
  endtask

  task automatic put3(input int a, input logic [11:0] v);
    put(a, v[11:8]); put(a + 1, v[7:4]); put(a + 2, v[3:0]);
  endtask

  task automatic halt_at(input int a);
    put(a, 4'h4); put3(a + 1, 12'(a));
  endtask

  task automatic go(input int cycles);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int u = 0; u < 16; u++) begin fb_data[u] = 4'h0; fb_stat[u] = 4'h0; end

    // R1 reset state and first fetch
    prep();
    halt_at(16);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first read request", int'(mem_rd), 1);
    check("R1 first read address", int'(mem_addr), 12'h010);
    check("R1 quiet write strobes", int'({mem_we, reg_we, fu_cwe}), 0);

    // R3 / R9 / R10 / R2 / R12 memory-to-memory copies
    prep();
    put(16, 4'h0); put3(17, 12'h200); put3(20, 12'h300);
    put(23, 4'h0); put3(24, 12'h009); put3(27, 12'h301);
    put(30, 4'h0); put3(31, 12'h201); put3(34, 12'h005);
    halt_at(37);
    put(12'h200, 4'h7); put(12'h201, 4'hC);
    go(60);
    check("R3 copy value", int'(mem[12'h300]), 7);
    check("R9 constant source", int'(mem[12'h301]), 9);
    check("R10 low region untouched", int'(mem[5]), 10);
    check("R10 no low write strobe", low_wr, 0);
    check("R12 source read after operands", int'(rlog[7]), 12'h200);
    check("R2 next opcode after six operands", int'(rlog[8]), 12'h017);
    check("R12 read/write overlap", both, 0);

    // R4 memory to register, every destination nybble
    for (int d = 0; d < 16; d++) begin
      prep();
      put(16, 4'h1); put3(17, 12'h250); put(20, 4'(d));
      halt_at(21);
      put(12'h250, 4'((d * 7 + 3) & 15));
      go(30);
      check($sformatf("R4 write count dest %0d", d), rw_cnt, (d < 2) ? 1 : 0);
      if (d < 2) begin
        check("R4 register select", int'(rw_sel), d);
        check("R4 register value", int'(rw_val), (d * 7 + 3) & 15);
      end
    end

    // R5 data to function carry, every data nybble
    for (int v = 0; v < 16; v++) begin
      prep();
      put(16, 4'h2); put(17, 4'(v)); put(18, 4'(v ^ 5));
      halt_at(19);
      go(25);
      check("R5 carry write count", cw_cnt, 1);
      check("R5 carry unit", int'(cw_unit), v ^ 5);
      check("R5 carry value", int'(cw_val), v & 1);
    end

    // R6 function data to memory, every unit
    for (int u = 0; u < 16; u++) fb_data[u] = 4'((u * 3 + 1) & 15);
    for (int u = 0; u < 16; u++) begin
      prep();
      put(16, 4'h3); put(17, 4'(u)); put3(18, 12'(12'h400 + u));
      halt_at(21);
      go(30);
      check("R6 stored unit data", int'(mem[12'h400 + u]), (u * 3 + 1) & 15);
      check("R6 one write", wcnt, 1);
    end
    prep();
    put(16, 4'h3); put(17, 4'h2); put3(18, 12'h00C);
    halt_at(21);
    go(30);
    check("R10 unit store to low region", wcnt, 0);
    check("R10 low region value", int'(mem[12]), 1);

    // R7 jump with every low-bit pattern
    for (int lo = 0; lo < 4; lo++) begin
      prep();
      put(16, 4'(4 | lo)); put3(17, 12'(12'hA5C ^ lo));
      halt_at(12'hA5C ^ lo);
      go(25);
      check("R7 jump landing", int'(rlog[4]), 12'hA5C ^ lo);
      check("R7 operand after landing", int'(rlog[5]), (12'hA5C ^ lo) + 1);
    end

    // R8 conditional jumps: bit, polarity and status value
    for (int k = 0; k < 4; k++)
      for (int t = 0; t < 2; t++)
        for (int v = 0; v < 2; v++) begin
          int u;
          logic [3:0] st;
          u = (k + 4 * t + 8 * v) & 15;
          st = v ? (4'b1 << k) : ~(4'b1 << k);
          for (int w = 0; w < 16; w++) fb_stat[w] = ~st;
          fb_stat[u] = st;
          prep();
          put(16, 4'((t ? 12 : 8) | k)); put(17, 4'(u)); put3(18, 12'h180);
          halt_at(21);
          halt_at(12'h180);
          go(30);
          check($sformatf("R8 bit %0d pol %0d val %0d", k, t, v),
                int'(rlog[5]), (v == t) ? 12'h180 : 12'h015);
        end

    // R11 wrap past 0xFFF into the constant table
    prep();
    put(16, 4'h4); put3(17, 12'hFFE);
    put(12'hFFE, 4'h2); put(12'hFFF, 4'h1);
    halt_at(12'h789);
    go(60);
    check("R11 wrap to zero", int'(rlog[6]), 12'h000);
    check("R11 carry from wrapped operand", cw_cnt, 1);
    check("R11 carry unit from constant", int'(cw_unit), 0);
    check("R11 constant opcode ignored dest", rw_cnt, 0);
    check("R11 constant-coded jump", int'(rlog[17]), 12'h789);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule